// File: doc/BRIEF.md
# Serial Configuration Port for a Banked Clock Divider

This block is the control front end of a four-bank clock divider. A host shifts a fixed-length configuration word into it over three wires: a serial clock, a data line and a load-enable strobe. The block holds the last accepted word and splits it into the controls the divider banks need. These controls are a 3-bit ratio code per bank, one enable per output (two outputs per bank) and the output signalling type of each bank. The three serial inputs are asynchronous to the block clock. They are resynchronised and edge-detected, so every serial event is handled as a single-cycle pulse in the `clk` domain.

A frame is loaded while load-enable is low and committed on the rising edge of load-enable. The commit happens only if exactly the frame length of serial clock edges arrived since load-enable last fell. Shorter and longer frames leave the held configuration alone. While load-enable is low, every output enable reads as disabled. The readback line always shows the most significant bit of the shift register. Shifting the next frame in therefore streams the previous word back out, MSB first, so the host can verify what it wrote. The serial pins and the decoded controls are plain level signals with no handshake. The host paces the frame with the serial clock and needs no back-pressure.

Top module: `clkdiv_cfg_serial`

## Requirements
- R1: A frame is 22 bits (4 banks x 3 ratio bits + 8 enables + 2 type bits), sent first-bit-first. Numbering the frame bits D22 (first sent) down to D1 (last sent), bit Dk sits at index k-1 of the held word.
- R2: Bank ratio codes are bank 3 from D22..D20, bank 2 from D19..D17, bank 1 from D16..D14 and bank 0 from D13..D11. Within each group the first-sent bit is code bit 0, the next is bit 1 and the last is bit 2. `ratio_codes[3b+2:3b]` carries bank b.
- R3: Output enable `out_en[2b+o]` (bank b, output o) is taken from frame bit D(3+2b+o). So D3 is bank 0 output 0 and D10 is bank 3 output 1. A value of 1 means enabled.
- R4: D1 sets the type of bank 0 and D2 sets the type of banks 1 to 3, with 1 = LVPECL and 0 = LVDS; `bank_lvpecl[b]` reports bank b. `type_mode` = {D2, D1}: 00 all LVDS, 11 all LVPECL, 10 bank 0 LVDS with the rest LVPECL, 01 bank 0 LVPECL with the rest LVDS.
- R5: Within 4 clk cycles of load-enable going low, `out_en` is all zero, whatever the held word is. The held ratio and type fields are kept.
- R6: The held word is replaced on a rising edge of load-enable only when exactly 22 serial clock rising edges were counted since load-enable last fell. A 21-bit or 23-bit frame leaves every decoded output unchanged.
- R7: After reset every output is disabled, all ratio codes are 0, every bank is LVDS, `type_mode` is 00 and `miso` is 0.
- R8: `miso` is the MSB of the shift register and changes only after a serial clock rising edge. During a frame, the bit seen before each rising edge is the previously shifted word, MSB first.
- R9: Serial clock edges while load-enable is high do not shift. `miso` and the shift register contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock (asynchronous) |
| sdata | input | 1 | Serial data, sampled on sclk rising edge |
| le | input | 1 | Load enable: low to shift, rising edge commits |
| miso | output | 1 | Readback line, shift register MSB |
| ratio_codes | output | 12 | Ratio code per bank, 3 bits each, bank 0 in the low bits |
| out_en | output | 8 | Per-output enable, index 2*bank+output |
| bank_lvpecl | output | 4 | Per-bank type, 1 = LVPECL |
| type_mode | output | 2 | Type mode {D2, D1} |

## Verification
The bench builds the block with its default parameters: four banks of two outputs, 3-bit ratio codes and a two-stage synchroniser. This gives the 22-bit frame, so the bench can reach the off-by-one frames either side of it. Each of the four type modes is committed at least once. The readback stream is compared against a bench-side model of the shifted bits across rejected frames and ignored serial clocks.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;
  typedef enum logic [1:0] {
    MODE_ALL_LVDS         = 2'b00,
    MODE_B0_PECL_REST_LVDS = 2'b01,
    MODE_B0_LVDS_REST_PECL = 2'b10,
    MODE_ALL_PECL         = 2'b11
  } type_mode_e;

  localparam int TYPE_BITS = 2;
endpackage

// File: rtl/cfgser_sync.sv
module cfgser_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cfgser_shifter.sv
module cfgser_shifter #(
  parameter int FRAME_BITS = 22,
  localparam int CNT_W = $clog2(FRAME_BITS + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift_en,
  input  logic                  cnt_clr,
  input  logic                  din,
  output logic [FRAME_BITS-1:0] sr_q,
  output logic [CNT_W-1:0]      cnt_q,
  output logic                  frame_exact
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_HIT = CNT_W'(FRAME_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (shift_en) begin
      sr_q <= {sr_q[FRAME_BITS-2:0], din};
    end
  end

  // Count saturates one past the frame length so any overlong frame stays distinguishable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_clr) begin
      cnt_q <= shift_en ? CNT_W'(1) : '0;
    end else if (shift_en && cnt_q != CNT_SAT) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign frame_exact = (cnt_q == CNT_HIT);
endmodule

// File: rtl/cfgser_decode.sv
module cfgser_decode #(
  parameter int NUM_BANKS = 4,
  parameter int RATIO_W   = 3,
  parameter int OUTS_PER  = 2,
  localparam int OE_BITS  = NUM_BANKS * OUTS_PER,
  localparam int RATIO_LO = OE_BITS + cfgser_pkg::TYPE_BITS,
  localparam int WORD_W   = NUM_BANKS * RATIO_W + RATIO_LO
) (
  input  logic [WORD_W-1:0]            word,
  output logic [NUM_BANKS*RATIO_W-1:0] ratio_codes,
  output logic [OE_BITS-1:0]           oe,
  output logic [NUM_BANKS-1:0]         bank_lvpecl,
  output cfgser_pkg::type_mode_e       mode
);
  // Each ratio group is sent code bit 0 first, so it lands bit-reversed in the word.
  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      for (genvar k = 0; k < RATIO_W; k++) begin : g_rbit
        assign ratio_codes[b*RATIO_W + k] = word[RATIO_LO + b*RATIO_W + (RATIO_W-1-k)];
      end
      if (b == 0) begin : g_t0
        assign bank_lvpecl[b] = word[0];
      end else begin : g_tn
        assign bank_lvpecl[b] = word[1];
      end
    end
  endgenerate

  assign oe   = word[cfgser_pkg::TYPE_BITS +: OE_BITS];
  assign mode = cfgser_pkg::type_mode_e'(word[1:0]);
endmodule

// File: rtl/clkdiv_cfg_serial.sv
module clkdiv_cfg_serial #(
  parameter int NUM_BANKS   = 4,
  parameter int RATIO_W     = 3,
  parameter int OUTS_PER    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sclk,
  input  logic                         sdata,
  input  logic                         le,
  output logic                         miso,
  output logic [NUM_BANKS*RATIO_W-1:0] ratio_codes,
  output logic [NUM_BANKS*OUTS_PER-1:0] out_en,
  output logic [NUM_BANKS-1:0]         bank_lvpecl,
  output logic [1:0]                   type_mode
);
  localparam int OE_BITS    = NUM_BANKS * OUTS_PER;
  localparam int FRAME_BITS = NUM_BANKS * RATIO_W + OE_BITS + cfgser_pkg::TYPE_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);

  logic sclk_s, sdata_s, le_s;
  logic sclk_d, le_d;
  logic sclk_rise, le_rise, le_fall, shift_en, commit;
  logic [FRAME_BITS-1:0] sr_q, held_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  frame_exact;
  logic [OE_BITS-1:0]    dec_oe;
  cfgser_pkg::type_mode_e dec_mode;

  cfgser_sync #(.STAGES(SYNC_STAGES)) u_sync_sclk (.clk(clk), .rst_n(rst_n), .d(sclk),  .q(sclk_s));
  cfgser_sync #(.STAGES(SYNC_STAGES)) u_sync_sdat (.clk(clk), .rst_n(rst_n), .d(sdata), .q(sdata_s));
  cfgser_sync #(.STAGES(SYNC_STAGES)) u_sync_le   (.clk(clk), .rst_n(rst_n), .d(le),    .q(le_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      le_d   <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      le_d   <= le_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign le_rise   = le_s & ~le_d;
  assign le_fall   = ~le_s & le_d;
  assign shift_en  = sclk_rise & ~le_s;

  cfgser_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .cnt_clr(le_fall),
    .din(sdata_s), .sr_q(sr_q), .cnt_q(cnt_q), .frame_exact(frame_exact)
  );

  assign commit = le_rise & frame_exact;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= '0;
    else if (commit) held_q <= sr_q;
  end

  cfgser_decode #(.NUM_BANKS(NUM_BANKS), .RATIO_W(RATIO_W), .OUTS_PER(OUTS_PER)) u_dec (
    .word(held_q), .ratio_codes(ratio_codes), .oe(dec_oe),
    .bank_lvpecl(bank_lvpecl), .mode(dec_mode)
  );

  assign out_en    = dec_oe & {OE_BITS{le_s}};
  assign type_mode = dec_mode;
  assign miso      = sr_q[FRAME_BITS-1];
endmodule

// File: rtl/clkdiv_cfg_serial_chk.sv
module clkdiv_cfg_serial_chk #(
  parameter int FRAME_BITS = 22,
  parameter int RBITS      = 12,
  parameter int OBITS      = 8,
  parameter int CNT_W      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             le,
  input logic             le_d,
  input logic             sdata_s,
  input logic             shift_en,
  input logic [CNT_W-1:0] cnt_q,
  input logic             sr_lsb,
  input logic             miso,
  input logic [RBITS-1:0] ratio_codes,
  input logic [1:0]       type_mode,
  input logic [OBITS-1:0] out_en
);
  // R5: load-enable held low at the pin forces every enable off.
  a_r5_le_low_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && !$past(le) && !$past(le, 2)) |-> (out_en == '0));

  // R6: held fields change only right after a load-enable rising edge.
  a_r6_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(le_d) |-> ($stable(ratio_codes) && $stable(type_mode)));

  // R8: readback moves only after an accepted serial clock edge.
  a_r8_miso_moves_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(shift_en) |-> $stable(miso));

  // R1: the newest sampled data bit enters at the bottom of the shift register.
  a_r1_shift_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $past(shift_en) |-> (sr_lsb == $past(sdata_s)));

  // R6: the bit counter never runs past its saturation point.
  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FRAME_BITS + 1));
endmodule

bind clkdiv_cfg_serial clkdiv_cfg_serial_chk #(
  .FRAME_BITS(FRAME_BITS), .RBITS(NUM_BANKS*RATIO_W), .OBITS(OE_BITS), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .le(le), .le_d(le_d), .sdata_s(sdata_s),
  .shift_en(shift_en), .cnt_q(cnt_q), .sr_lsb(sr_q[0]), .miso(miso),
  .ratio_codes(ratio_codes), .type_mode(type_mode), .out_en(out_en)
);

// File: tb/clkdiv_cfg_serial_tb_top.sv
module clkdiv_cfg_serial_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, le = 1'b0;
  logic miso;
  logic [11:0] ratio_codes;
  logic [7:0]  out_en;
  logic [3:0]  bank_lvpecl;
  logic [1:0]  type_mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [21:0] model_sr = '0;
  logic [11:0] exp_ratio = '0;
  logic [7:0]  exp_oe = '0;
  logic [1:0]  exp_t = '0;

  always #5 clk = ~clk;

  clkdiv_cfg_serial dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .le(le), .miso(miso),
    .ratio_codes(ratio_codes), .out_en(out_en), .bank_lvpecl(bank_lvpecl), .type_mode(type_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Frame bit Dk at word[k-1]; ratio group sent bit 0 first (R1, R2, R3, R4).
  function automatic logic [21:0] mk_word(input logic [11:0] r, input logic [7:0] oe, input logic [1:0] t);
    logic [21:0] w;
    w = '0;
    for (int b = 0; b < 4; b++) begin
      w[12+3*b] = r[3*b];
      w[11+3*b] = r[3*b+1];
      w[10+3*b] = r[3*b+2];
    end
    w[9:2] = oe;
    w[1:0] = t;
    return w;
  endfunction

  task automatic sclk_bit(input logic b, output logic rb);
    rb = miso;
    sdata = b;
    repeat (4) @(posedge clk);
    #1 sclk = 1'b1;
    if (!le) model_sr = {model_sr[20:0], b};
    repeat (4) @(posedge clk);
    #1 sclk = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] w, input int n, output logic [31:0] rb);
    logic r;
    rb = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sclk_bit(w[i], r);
      rb = {rb[30:0], r};
    end
    repeat (6) @(posedge clk);
  endtask

  task automatic check_fields(input string req);
    chk({req, " ratio"}, 32'(ratio_codes), 32'(exp_ratio));
    chk({req, " type_mode"}, 32'(type_mode), 32'(exp_t));
    chk({req, " bank_lvpecl"}, 32'(bank_lvpecl), 32'({exp_t[1], exp_t[1], exp_t[1], exp_t[0]}));
  endtask

  task automatic le_commit_check(input string req);
    #1 le = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    check_fields(req);
    chk({req, " out_en le high"}, 32'(out_en), 32'(exp_oe));
    le = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk("R5 out_en forced off with le low", 32'(out_en), 32'h0);
    check_fields("R5 fields kept with le low");
  endtask

  task automatic t_reset;
    #1;
    chk("R7 ratio reset", 32'(ratio_codes), 32'h0);
    chk("R7 out_en reset", 32'(out_en), 32'h0);
    chk("R7 bank type reset", 32'(bank_lvpecl), 32'h0);
    chk("R7 type_mode reset", 32'(type_mode), 32'h0);
    chk("R7 miso reset", 32'(miso), 32'h0);
  endtask

  task automatic t_write(input logic [11:0] r, input logic [7:0] oe, input logic [1:0] t, input string req);
    logic [31:0] rb;
    logic [21:0] prev;
    prev = model_sr;
    send_bits(32'(mk_word(r, oe, t)), 22, rb);
    chk("R8 readback of previous word", 32'(rb[21:0]), 32'(prev));
    exp_ratio = r; exp_oe = oe; exp_t = t;
    le_commit_check(req);
  endtask

  task automatic t_bad_len(input int n);
    logic [31:0] rb;
    send_bits(32'hFFFF_FFFF, n, rb);
    le_commit_check($sformatf("R6 %0d-bit frame rejected", n));
  endtask

  task automatic t_ignore_le_high;
    logic r, m0;
    logic [31:0] rb;
    logic [21:0] keep;
    #1 le = 1'b1;
    repeat (4) @(posedge clk);
    keep = model_sr;
    m0 = miso;
    for (int i = 0; i < 3; i++) sclk_bit(~m0, r);
    repeat (6) @(posedge clk);
    #1;
    chk("R9 miso unchanged by sclk with le high", 32'(miso), 32'(m0));
    le = 1'b0;
    repeat (6) @(posedge clk);
    send_bits(32'(mk_word(12'hFAC, 8'h0F, 2'b00)), 22, rb);
    chk("R9 shift register untouched with le high", 32'(rb[21:0]), 32'(keep));
    exp_ratio = 12'hFAC; exp_oe = 8'h0F; exp_t = 2'b00;
    le_commit_check("R4 mode 00 all LVDS");
  endtask

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_write(12'b011_010_001_110, 8'b1010_0101, 2'b01, "R2 R3 R4 mode 01");
    t_write(12'b111_100_101_011, 8'b0110_1001, 2'b10, "R1 R2 R3 R4 mode 10");
    t_bad_len(21);
    t_bad_len(23);
    t_write(12'b001_011_000_111, 8'b1000_0001, 2'b11, "R2 R3 R4 mode 11");
    t_ignore_le_high();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule